// File: doc/BRIEF.md
# Held Position Output Register with Byte Lanes

This block sits between a free-running position counter and a host that reads the position one byte at a time. It keeps a registered copy of the 16-bit count and loads it on every count-update strobe. The host drives a freeze input low to stop these loads, so that the two bytes it reads come from the same sample. Counting upstream is not disturbed. While the freeze is held, a timer runs for a programmable number of cycles and then raises a data-ready flag. Releasing the freeze reloads the register straight away and issues a one-cycle refresh pulse.

The held word is presented on two 8-bit lanes. Tri-state is modelled as a data bus plus a drive flag for each lane. The secondary lane always carries the low byte. The primary lane carries the high byte when the byte-select input is high, and a copy of the low byte when it is low. A resolution parameter below 16 clears the unused low-order bits of the held word.

Top module: `pos_out_latch`

## Requirements
- R1: During reset and after its release, both drive flags, both lane buses, the refresh pulse and the ready flag are 0, and the held word is 0.
- R2: At a clock edge that samples `hold_n`=1 and `upd_stb`=1, the held word takes `count_in` (masked per R9). The lanes show the new word after the following edge.
- R3: At a clock edge that samples `hold_n`=0, the held word is unchanged, whatever `upd_stb` and `count_in` are.
- R4: At an edge that samples `hold_n`=1 while the previous edge sampled 0, the held word reloads from `count_in` and `refresh_stb` is 1 for exactly one cycle after that edge. It is 0 at all other times.
- R5: `data_ok` goes to 1 after the edge that completes `VALID_CYC` consecutive edges sampling `hold_n`=0. It stays 1 while `hold_n` stays 0, and is 0 after any edge that samples `hold_n`=1.
- R6: After an edge that samples `oe_n`=1, both drive flags and both buses are 0. After an edge that samples `oe_n`=0, both drive flags are 1.
- R7: When driven, the secondary bus equals bits [7:0] of the held word, whatever `hi_sel` is.
- R8: When driven, the primary bus equals bits [15:8] of the held word if `hi_sel` was 1 at the previous edge, and bits [7:0] if it was 0.
- R9: The low (16-`RES_BITS`) bits of the held word are always 0, so those lines are driven low.
- R10: `oe_n` and `hi_sel` have no effect on the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| count_in | input | 16 | Live position count |
| upd_stb | input | 1 | Count-update strobe, one cycle per step |
| hold_n | input | 1 | Freeze, active low: blocks loads into the held word |
| oe_n | input | 1 | Output enable, active low |
| hi_sel | input | 1 | Byte select for the primary lane (1 = high byte) |
| pri_bus | output | 8 | Primary lane data |
| pri_drive | output | 1 | Primary lane drive flag |
| sec_bus | output | 8 | Secondary lane data, always the low byte |
| sec_drive | output | 1 | Secondary lane drive flag |
| refresh_stb | output | 1 | One-cycle pulse after the freeze is released |
| data_ok | output | 1 | Held word stable and ready to read during a freeze |

## Verification
Directed sequences cover a strobed load, then a freeze that strobes a different count. This shows a word that is truly held apart from one that is merely reloaded with the same value. They also run a freeze long enough to reach the ready delay and then release it, which shows the timer threshold and the refresh reload. A count with all low bits set shows that the masking is active. Random stimulus then mixes freeze phases of random length (short ones that end before the ready delay, long ones that pass it) with random strobes, enables and byte selects. Each random cycle is compared against a cycle-level model, which separates the lane-selection rules from the register latency.

// File: rtl/pol_pkg.sv
package pol_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;

  // Mask that keeps the top res bits of a word and clears the rest.
  function automatic logic [WORD_W-1:0] keep_mask(input int res);
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = (i >= WORD_W - res);
    return m;
  endfunction
endpackage

// File: rtl/pol_capture.sv
module pol_capture #(
  parameter int DW       = 16,
  parameter int RES_BITS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] count_in,
  input  logic          upd_stb,
  input  logic          hold_n,
  output logic [DW-1:0] word_q,
  output logic          refresh_q
);
  localparam logic [DW-1:0] MASK = pol_pkg::keep_mask(RES_BITS);

  logic hold_q;
  logic released;
  logic load;

  assign released = hold_n & ~hold_q;
  assign load     = hold_n & (upd_stb | ~hold_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b1;
      word_q    <= '0;
      refresh_q <= 1'b0;
    end else begin
      hold_q    <= hold_n;
      refresh_q <= released;
      if (load) word_q <= count_in & MASK;
    end
  end
endmodule

// File: rtl/pol_ready_timer.sv
module pol_ready_timer #(
  parameter int VALID_CYC = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_n,
  output logic ready_q
);
  localparam int TW = $clog2(VALID_CYC + 1);
  localparam logic [TW-1:0] LIMIT = TW'(VALID_CYC);

  logic [TW-1:0] wait_q;
  logic [TW-1:0] wait_nx;

  always_comb begin
    wait_nx = wait_q;
    if (wait_q != LIMIT) wait_nx = wait_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || hold_n) begin
      wait_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      wait_q  <= wait_nx;
      ready_q <= (wait_nx == LIMIT);
    end
  end
endmodule

// File: rtl/pol_lanes.sv
module pol_lanes #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] word,
  input  logic          oe_n,
  input  logic          hi_sel,
  output logic [BW-1:0] pri_bus,
  output logic          pri_drive,
  output logic [BW-1:0] sec_bus,
  output logic          sec_drive
);
  localparam int NL = 2;

  logic [BW-1:0] lane_d [NL];
  logic          lane_e [NL];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [BW-1:0] pick;
    // lane 1 is primary and follows the byte select; lane 0 is always the low byte
    if (l == 1) begin : g_pri
      assign pick = hi_sel ? word[DW-1 -: BW] : word[BW-1:0];
    end else begin : g_sec
      assign pick = word[BW-1:0];
    end
    always_ff @(posedge clk) begin
      if (rst || oe_n) begin
        lane_d[l] <= '0;
        lane_e[l] <= 1'b0;
      end else begin
        lane_d[l] <= pick;
        lane_e[l] <= 1'b1;
      end
    end
  end

  assign pri_bus   = lane_d[1];
  assign pri_drive = lane_e[1];
  assign sec_bus   = lane_d[0];
  assign sec_drive = lane_e[0];
endmodule

// File: rtl/pos_out_latch.sv
module pos_out_latch #(
  parameter int RES_BITS  = 16,
  parameter int VALID_CYC = 60
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] count_in,
  input  logic        upd_stb,
  input  logic        hold_n,
  input  logic        oe_n,
  input  logic        hi_sel,
  output logic [7:0]  pri_bus,
  output logic        pri_drive,
  output logic [7:0]  sec_bus,
  output logic        sec_drive,
  output logic        refresh_stb,
  output logic        data_ok
);
  localparam int DW = pol_pkg::WORD_W;
  localparam int BW = pol_pkg::BYTE_W;

  logic [DW-1:0] word_q;

  pol_capture #(.DW(DW), .RES_BITS(RES_BITS)) u_cap (
    .clk(clk), .rst(rst), .count_in(count_in), .upd_stb(upd_stb),
    .hold_n(hold_n), .word_q(word_q), .refresh_q(refresh_stb)
  );

  pol_ready_timer #(.VALID_CYC(VALID_CYC)) u_tmr (
    .clk(clk), .rst(rst), .hold_n(hold_n), .ready_q(data_ok)
  );

  pol_lanes #(.DW(DW), .BW(BW)) u_lanes (
    .clk(clk), .rst(rst), .word(word_q), .oe_n(oe_n), .hi_sel(hi_sel),
    .pri_bus(pri_bus), .pri_drive(pri_drive),
    .sec_bus(sec_bus), .sec_drive(sec_drive)
  );
endmodule

// File: rtl/pos_out_latch_chk.sv
module pos_out_latch_chk #(
  parameter int RES_BITS = 16
) (
  input logic        clk,
  input logic        rst,
  input logic [15:0] count_in,
  input logic        upd_stb,
  input logic        hold_n,
  input logic        oe_n,
  input logic        hi_sel,
  input logic [7:0]  pri_bus,
  input logic        pri_drive,
  input logic [7:0]  sec_bus,
  input logic        sec_drive,
  input logic        refresh_stb,
  input logic        data_ok,
  input logic [15:0] word_q
);
  localparam logic [15:0] MASK = pol_pkg::keep_mask(RES_BITS);

  a_r2_load_on_strobe: assert property (@(posedge clk) disable iff (rst)
    (hold_n && upd_stb) |=> word_q == ($past(count_in) & MASK));

  a_r3_frozen_word: assert property (@(posedge clk) disable iff (rst)
    !hold_n |=> $stable(word_q));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    refresh_stb |=> !refresh_stb);

  a_r4_pulse_on_release: assert property (@(posedge clk) disable iff (rst)
    refresh_stb |-> $past(hold_n));

  a_r5_ready_drops: assert property (@(posedge clk) disable iff (rst)
    hold_n |=> !data_ok);

  a_r6_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    oe_n |=> (!pri_drive && !sec_drive && pri_bus == 8'h00 && sec_bus == 8'h00));

  a_r6_drive_when_on: assert property (@(posedge clk) disable iff (rst)
    !oe_n |=> (pri_drive && sec_drive));

  a_r8_low_copy: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !hi_sel) |=> pri_bus == sec_bus);

  a_r9_low_lines_zero: assert property (@(posedge clk) disable iff (rst)
    (word_q & ~MASK) == 16'h0000);
endmodule

bind pos_out_latch pos_out_latch_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst(rst), .count_in(count_in), .upd_stb(upd_stb),
  .hold_n(hold_n), .oe_n(oe_n), .hi_sel(hi_sel),
  .pri_bus(pri_bus), .pri_drive(pri_drive), .sec_bus(sec_bus),
  .sec_drive(sec_drive), .refresh_stb(refresh_stb), .data_ok(data_ok),
  .word_q(word_q)
);

// File: tb/sim_pos_out_latch.sv
module sim_pos_out_latch;
  localparam int RES = 12;
  localparam int VC  = 60;
  localparam logic [15:0] MSK = 16'hFFF0; // top 12 of 16 bits kept

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst = 1'b1;
  logic [15:0] count_in = '0;
  logic        upd_stb = 1'b0, hold_n = 1'b1, oe_n = 1'b1, hi_sel = 1'b0;
  logic [7:0]  pri_bus, sec_bus;
  logic        pri_drive, sec_drive, refresh_stb, data_ok;

  pos_out_latch #(.RES_BITS(RES), .VALID_CYC(VC)) u0 (
    .clk(clk), .rst(rst), .count_in(count_in), .upd_stb(upd_stb),
    .hold_n(hold_n), .oe_n(oe_n), .hi_sel(hi_sel),
    .pri_bus(pri_bus), .pri_drive(pri_drive), .sec_bus(sec_bus),
    .sec_drive(sec_drive), .refresh_stb(refresh_stb), .data_ok(data_ok)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // reference model state
  logic [15:0] m_word;
  logic        m_hprev, m_ref, m_ok, m_pd, m_sd;
  logic [7:0]  m_pb, m_sb;
  int          m_wait;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (rst) begin
      m_word = '0; m_hprev = 1'b1; m_ref = 0; m_ok = 0; m_wait = 0;
      m_pd = 0; m_sd = 0; m_pb = '0; m_sb = '0;
    end else begin
      m_pd = !oe_n; m_sd = !oe_n;
      m_sb = oe_n ? 8'h00 : m_word[7:0];
      m_pb = oe_n ? 8'h00 : (hi_sel ? m_word[15:8] : m_word[7:0]);
      m_ref = hold_n && !m_hprev;
      if (hold_n && (upd_stb || !m_hprev)) m_word = count_in & MSK;
      if (hold_n) begin m_wait = 0; m_ok = 0; end
      else begin
        if (m_wait < VC) m_wait++;
        m_ok = (m_wait == VC);
      end
      m_hprev = hold_n;
    end
  endtask

  // one clock: model update at the edge, compare shortly after, return at falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    #1;
    chk("R8 pri_bus", {8'h00, pri_bus}, {8'h00, m_pb});
    chk("R7 sec_bus", {8'h00, sec_bus}, {8'h00, m_sb});
    chk("R6 drive", {14'h0, pri_drive, sec_drive}, {14'h0, m_pd, m_sd});
    chk("R4 refresh_stb", {15'h0, refresh_stb}, {15'h0, m_ref});
    chk("R5 data_ok", {15'h0, data_ok}, {15'h0, m_ok});
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; oe_n = 1'b0; upd_stb = 1'b1; count_in = 16'hFFFF;
    tick(); tick();
    // R1: reset state
    chk("R1 reset drive", {14'h0, pri_drive, sec_drive}, 16'h0);
    chk("R1 reset buses", {pri_bus, sec_bus}, 16'h0);
    chk("R1 reset flags", {14'h0, refresh_stb, data_ok}, 16'h0);
    rst = 1'b0; upd_stb = 1'b0;
    tick();
    chk("R1 word zero after reset", {pri_bus, sec_bus}, 16'h0000);

    // R2 + R9: strobed load, all low bits set in count
    hold_n = 1'b1; oe_n = 1'b0; hi_sel = 1'b1; upd_stb = 1'b1; count_in = 16'hABCF;
    tick();
    upd_stb = 1'b0; count_in = 16'h0000;
    tick();
    chk("R2 high byte loaded", {8'h00, pri_bus}, 16'h00AB);
    chk("R9 low lines forced low", {8'h00, sec_bus}, 16'h00C0);

    // R3: freeze, strobe other counts
    hold_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      upd_stb = 1'b1; count_in = 16'h1234 + 16'(i);
      tick();
    end
    upd_stb = 1'b0;
    tick();
    chk("R3 frozen word held", {pri_bus, sec_bus}, 16'hABC0);

    // R5: wait until ready
    for (int i = 0; i < VC; i++) tick();
    chk("R5 ready after delay", {15'h0, data_ok}, 16'h1);

    // R10: toggle enable and select while frozen, then read
    oe_n = 1'b1; hi_sel = 1'b0; tick(); tick();
    hi_sel = 1'b1; tick();
    oe_n = 1'b0; hi_sel = 1'b0; tick();
    chk("R10 low byte intact", {8'h00, pri_bus}, 16'h00C0);
    hi_sel = 1'b1; tick();
    chk("R10 high byte intact", {8'h00, pri_bus}, 16'h00AB);

    // R4: release reloads and pulses
    count_in = 16'h5A5F; hold_n = 1'b1;
    tick();
    chk("R4 refresh pulse", {15'h0, refresh_stb}, 16'h1);
    tick();
    chk("R4 refresh single", {15'h0, refresh_stb}, 16'h0);
    chk("R4 reload on release", {pri_bus, sec_bus}, 16'h5A50);

    // random phase
    begin
      int seed_dummy;
      int phase_left;
      seed_dummy = $urandom(32'd1357);
      phase_left = 0;
      for (int c = 0; c < 6000; c++) begin
        if (phase_left == 0) begin
          hold_n = ($urandom_range(0, 2) != 0);
          phase_left = hold_n ? $urandom_range(1, 20) : $urandom_range(1, 2 * VC);
        end
        phase_left--;
        upd_stb  = ($urandom_range(0, 3) == 0);
        count_in = 16'($urandom);
        oe_n     = ($urandom_range(0, 4) == 0);
        hi_sel   = $urandom_range(0, 1) != 0;
        tick();
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule